// File: doc/BRIEF.md
# Three-Source Minterm Block Blitter

This block moves and combines rectangles of 16-bit words in a word-addressed memory. For each destination word it can fetch one word from each of up to three source streams, called A, B and C. Each fetched word can be shifted by 0 to 15 bit positions, with the bits pushed out carried into the next word of the same line. The three shifted words are then merged bit by bit under an 8-bit function code. An optional toggle fill turns outline pixels into solid horizontal spans. The result is written to the destination stream D.

A user sets up the configuration inputs and pulses `start`. The inputs are the base pointers, the per-channel stride, the width in words, the height in lines, the shift, the direction, the enabled sources, the function code and the fill enable. The block holds `busy` high while it walks the rectangle, then pulses `done`. Memory reads return data on the cycle after they are issued.

Top module: `blit_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_en` are all low.
- R2: Destination bit i equals `func[{a_i,b_i,c_i}]`, where a_i, b_i and c_i are bit i of the shifted A, B and C words. For example, code 0xF0 gives D = A and code 0xF8 gives D = (C AND B) OR A.
- R3: A source whose `src_en` bit is low (bit 0 = A, bit 1 = B, bit 2 = C) reads as zero and is never fetched. Each destination word costs exactly one read per enabled source.
- R4: The block spans `width_w` words by `height_l` lines. Within a line, consecutive words sit at consecutive addresses. After the last word of a line, each pointer moves by one more word plus that channel's stride.
- R5: With `descend` high, every base pointer names the last word of its area. Addresses then decrease and strides are subtracted. This makes a move to an overlapping higher area produce an exact copy.
- R6: In ascending mode a source word w with previous word p of the same line becomes ((p:w) >> shift)[15:0]. Here p is zero for the first word of every line.
- R7: In descending mode a source word w with previous word p becomes ((w:p) << shift)[31:16]. Here p is zero for the first word of every line.
- R8: With `fill_en` high, the function output is scanned from bit 0 up to bit 15, word after word in processing order. Each set bit toggles a fill state, and an output bit is set if its input bit is set or the state was on before it. The state starts off on every line.
- R9: `busy` rises on the cycle after `start` in idle. It falls on the cycle after the last destination write, and `done` is high for exactly that one cycle. A `start` pulse while busy is ignored.
- R10: With the default parameters, blocks of up to 64 words by 1024 lines (1024 by 1024 pixels) are carried out in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| src_en | input | 3 | Source enables: bit0 A, bit1 B, bit2 C |
| func | input | 8 | Minterm function code |
| shift | input | 4 | Source shift amount |
| descend | input | 1 | 1 = walk from block end toward lower addresses |
| fill_en | input | 1 | Enable toggle span fill |
| width_w | input | 7 | Width in words (1..64) |
| height_l | input | 11 | Height in lines (1..1024) |
| base_a | input | 16 | A pointer start |
| base_b | input | 16 | B pointer start |
| base_c | input | 16 | C pointer start |
| base_d | input | 16 | D pointer start |
| stride_a | input | 16 | A extra step between lines |
| stride_b | input | 16 | B extra step between lines |
| stride_c | input | 16 | C extra step between lines |
| stride_d | input | 16 | D extra step between lines |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |

## Verification
The assertions assume that `width_w` and `height_l` are never zero when `start` is pulsed. They also assume that the memory returns read data exactly one cycle after the read strobe. The bench only issues non-zero sizes and models a one-cycle read memory. Configuration inputs are held steady for the whole run, except for a deliberate change made together with a second `start` pulse, which must have no effect.

// File: rtl/blit_pkg.sv
package blit_pkg;
   typedef enum logic [1:0] {CH_A = 2'd0, CH_B = 2'd1, CH_C = 2'd2, CH_D = 2'd3} chan_e;
   typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_e;
endpackage

// File: rtl/blit_shifter.sv
module blit_shifter #(
   parameter int DW  = 16,
   parameter int SHW = $clog2(DW)
) (
   input  logic [DW-1:0]  raw,
   input  logic [DW-1:0]  carry,
   input  logic [SHW-1:0] sh,
   input  logic           desc,
   output logic [DW-1:0]  out
);
   logic [2*DW-1:0] asc_w, dsc_w;

   generate
      if ((1 << SHW) != DW) begin : g_bad_width
         $error("blit_shifter: DW must be a power of two");
      end
   endgenerate

   always_comb begin
      asc_w = {carry, raw} >> sh;
      dsc_w = {raw, carry} << sh;
      out   = desc ? dsc_w[2*DW-1:DW] : asc_w[DW-1:0];
   end

   // R6
   always_comb begin
      if (!$isunknown({sh, raw}) && sh == '0)
         zero_shift_chk: assert (out == raw);
   end
endmodule

// File: rtl/blit_minterm.sv
module blit_minterm #(
   parameter int DW = 16
) (
   input  logic [7:0]    code,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] c,
   output logic [DW-1:0] y
);
   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign y[i] = code[{a[i], b[i], c[i]}];
   end

   // R2
   always_comb begin
      if (!$isunknown({code, a, b, c}) && code == 8'hF8)
         mask_copy_chk: assert (y == ((c & b) | a));
   end
endmodule

// File: rtl/blit_fill.sv
module blit_fill #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] din,
   input  logic          st_in,
   output logic [DW-1:0] dout,
   output logic          st_out
);
   always_comb begin
      logic st;
      st = st_in;
      for (int i = 0; i < DW; i++) begin
         dout[i] = din[i] | st;
         st      = st ^ din[i];
      end
      st_out = st;
   end

   // R8
   always_comb begin
      if (!$isunknown({din, st_in}))
         fill_cover_chk: assert ((dout & din) == din);
   end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
   import blit_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 16,
   parameter int MAX_WORDS = 64,
   parameter int MAX_LINES = 1024,
   parameter int SHW       = $clog2(DW),
   parameter int WCW       = $clog2(MAX_WORDS + 1),
   parameter int HCW       = $clog2(MAX_LINES + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [2:0]     src_en,
   input  logic [7:0]     func,
   input  logic [SHW-1:0] shift,
   input  logic           descend,
   input  logic           fill_en,
   input  logic [WCW-1:0] width_w,
   input  logic [HCW-1:0] height_l,
   input  logic [AW-1:0]  base_a,
   input  logic [AW-1:0]  base_b,
   input  logic [AW-1:0]  base_c,
   input  logic [AW-1:0]  base_d,
   input  logic [AW-1:0]  stride_a,
   input  logic [AW-1:0]  stride_b,
   input  logic [AW-1:0]  stride_c,
   input  logic [AW-1:0]  stride_d,
   output logic           busy,
   output logic           done,
   output logic           mem_en,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata
);
   localparam int NSRC = 3;

   generate
      if (MAX_WORDS < 1 || MAX_LINES < 1) begin : g_bad_size
         $error("blit_engine: sizes must be positive");
      end
   endgenerate

   state_e               state_q;
   chan_e                ch_q, pend_ch_q;
   logic                 pend_v_q, done_q, fill_st_q;
   logic [2:0]           en_q;
   logic [7:0]           func_q;
   logic [SHW-1:0]       shift_q;
   logic                 desc_q, fill_q;
   logic [WCW-1:0]       width_q, col_q;
   logic [HCW-1:0]       height_q, row_q;
   logic [3:0][AW-1:0]   ptr_q, stride_q;
   logic [NSRC-1:0][DW-1:0] raw_q, carry_q, shifted;
   logic [DW-1:0]        mint, filled;
   logic                 fill_st_nx, ch_en, line_end, last_line;

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      blit_shifter #(.DW(DW), .SHW(SHW)) u_shift (
         .raw(raw_q[k]), .carry(carry_q[k]), .sh(shift_q),
         .desc(desc_q), .out(shifted[k]));
   end

   blit_minterm #(.DW(DW)) u_mint (
      .code(func_q), .a(shifted[0]), .b(shifted[1]), .c(shifted[2]), .y(mint));

   blit_fill #(.DW(DW)) u_fill (
      .din(mint), .st_in(fill_st_q), .dout(filled), .st_out(fill_st_nx));

   always_comb begin
      case (ch_q)
         CH_A:    ch_en = en_q[0];
         CH_B:    ch_en = en_q[1];
         CH_C:    ch_en = en_q[2];
         default: ch_en = 1'b1;
      endcase
      line_end  = (col_q == width_q - 1'b1);
      last_line = (row_q == height_q - 1'b1);
      busy      = (state_q == ST_RUN);
      done      = done_q;
      mem_we    = busy && (ch_q == CH_D);
      mem_en    = busy && ((ch_q != CH_D) ? ch_en : !pend_v_q);
      mem_addr  = ptr_q[ch_q];
      mem_wdata = fill_q ? filled : mint;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ch_q      <= CH_A;
         pend_ch_q <= CH_A;
         pend_v_q  <= 1'b0;
         done_q    <= 1'b0;
         fill_st_q <= 1'b0;
         en_q      <= '0;
         func_q    <= '0;
         shift_q   <= '0;
         desc_q    <= 1'b0;
         fill_q    <= 1'b0;
         width_q   <= '0;
         height_q  <= '0;
         col_q     <= '0;
         row_q     <= '0;
         ptr_q     <= '0;
         stride_q  <= '0;
         raw_q     <= '0;
         carry_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (pend_v_q) begin
            for (int k = 0; k < NSRC; k++)
               if (pend_ch_q == chan_e'(k)) raw_q[k] <= mem_rdata;
            pend_v_q <= 1'b0;
         end
         case (state_q)
            ST_IDLE: if (start) begin
               en_q      <= src_en;
               func_q    <= func;
               shift_q   <= shift;
               desc_q    <= descend;
               fill_q    <= fill_en;
               width_q   <= width_w;
               height_q  <= height_l;
               ptr_q     <= {base_d, base_c, base_b, base_a};
               stride_q  <= {stride_d, stride_c, stride_b, stride_a};
               col_q     <= '0;
               row_q     <= '0;
               ch_q      <= CH_A;
               raw_q     <= '0;
               carry_q   <= '0;
               fill_st_q <= 1'b0;
               state_q   <= ST_RUN;
            end
            default: begin
               if (ch_q != CH_D) begin
                  if (ch_en) begin
                     pend_v_q  <= 1'b1;
                     pend_ch_q <= ch_q;
                  end
                  ch_q <= chan_e'(ch_q + 2'd1);
               end else if (!pend_v_q) begin
                  for (int k = 0; k < 4; k++) begin
                     if (desc_q) ptr_q[k] <= ptr_q[k] - AW'(1) - (line_end ? stride_q[k] : '0);
                     else        ptr_q[k] <= ptr_q[k] + AW'(1) + (line_end ? stride_q[k] : '0);
                  end
                  carry_q   <= line_end ? '0 : raw_q;
                  fill_st_q <= line_end ? 1'b0 : fill_st_nx;
                  ch_q      <= CH_A;
                  if (line_end) begin
                     col_q <= '0;
                     row_q <= row_q + 1'b1;
                     if (last_line) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  end else begin
                     col_q <= col_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   // R9
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R9
   idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_en);
   // R3
   disabled_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |-> ch_en);
   // R4
   row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (row_q < height_q && col_q < width_q));
   // R9
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(func_q));
endmodule

// File: tb/tb_blit_engine.sv
module tb_blit_engine;
   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [2:0] src_en = '0;
   logic [7:0] func = '0;
   logic [3:0] shift = '0;
   logic descend = 1'b0, fill_en = 1'b0;
   logic [6:0] width_w = 7'd1;
   logic [10:0] height_l = 11'd1;
   logic [15:0] base_a = '0, base_b = '0, base_c = '0, base_d = '0;
   logic [15:0] stride_a = '0, stride_b = '0, stride_c = '0, stride_d = '0;
   logic busy, done, mem_en, mem_we;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;

   logic [15:0] mem [0:4095];
   logic [15:0] mm  [0:4095];
   int n_tests = 0, n_fail = 0, n_rd = 0, n_wr = 0, n_done = 0, cyc = 0;
   bit timed_out = 0;

   always #4 clk = ~clk;

   blit_engine dut (
      .clk, .rst_n, .start, .src_en, .func, .shift, .descend, .fill_en,
      .width_w, .height_l, .base_a, .base_b, .base_c, .base_d,
      .stride_a, .stride_b, .stride_c, .stride_d,
      .busy, .done, .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (done) n_done <= n_done + 1;
      if (mem_en) begin
         if (mem_we) begin mem[mem_addr[11:0]] <= mem_wdata; n_wr <= n_wr + 1; end
         else begin mem_rdata <= mem[mem_addr[11:0]]; n_rd <= n_rd + 1; end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] sh_word(logic [15:0] w, logic [15:0] p, int s, bit d);
      logic [31:0] t;
      if (d) begin t = {w, p} << s; return t[31:16]; end
      t = {p, w} >> s; return t[15:0];
   endfunction

   // Reference: walks the rectangle on mm following R2..R8.
   task automatic model();
      int p[4]; int st[4];
      logic [15:0] car[3], raw[3], sv[3], res;
      bit fs;
      p  = '{int'(base_a), int'(base_b), int'(base_c), int'(base_d)};
      st = '{int'(stride_a), int'(stride_b), int'(stride_c), int'(stride_d)};
      for (int r = 0; r < height_l; r++) begin
         car = '{16'h0, 16'h0, 16'h0};
         fs = 0;
         for (int w = 0; w < width_w; w++) begin
            for (int k = 0; k < 3; k++) begin
               raw[k] = src_en[k] ? mm[p[k] & 4095] : 16'h0;
               sv[k]  = sh_word(raw[k], car[k], shift, descend);
               car[k] = raw[k];
            end
            for (int i = 0; i < 16; i++) res[i] = func[{sv[0][i], sv[1][i], sv[2][i]}];
            if (fill_en)
               for (int i = 0; i < 16; i++) begin
                  bit b = res[i];
                  res[i] = b | fs;
                  fs = fs ^ b;
               end
            mm[p[3] & 4095] = res;
            for (int k = 0; k < 4; k++) begin
               int dl = 1 + ((w == width_w - 1) ? st[k] : 0);
               p[k] = (descend ? p[k] - dl : p[k] + dl) & 16'hFFFF;
            end
         end
      end
   endtask

   task automatic run(input string req, input int exp_rd, input bit ignore_start = 0);
      int t = 0;
      for (int i = 0; i < 4096; i++) mm[i] = mem[i];
      model();
      n_rd = 0; n_wr = 0; n_done = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy === 1'b1, "R9", busy, 1);
      if (ignore_start) begin
         repeat (5) @(negedge clk);
         func = ~func; start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      while (n_done == 0 && t < 20000 && !timed_out) begin @(negedge clk); t++; end
      @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && n_done == 1, "R9", n_done, 1);
      if (exp_rd >= 0) check(n_rd == exp_rd, {req, "/R3"}, n_rd, exp_rd);
      begin
         int bad = 0;
         for (int i = 0; i < 4096; i++) if (mem[i] !== mm[i]) bad++;
         check(bad == 0, req, bad, 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 40503) ^ 16'(i >> 3);
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy === 0 && done === 0 && mem_en === 0, "R1", {busy, done, mem_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 0 && done === 0 && mem_en === 0, "R1", {busy, done, mem_en}, 0);

      // R2: every function code on fixed operands
      mem[100] = 16'hFF00; mem[101] = 16'hF0F0; mem[102] = 16'hCCCC;
      base_a = 100; base_b = 101; base_c = 102; base_d = 200; src_en = 3'b111;
      for (int f = 0; f < 256; f++) begin
         logic [15:0] e;
         func = 8'(f);
         for (int i = 0; i < 16; i++) e[i] = func[{mem[100][i], mem[101][i], mem[102][i]}];
         run("R2", 3);
         check(mem[200] == e, "R2", mem[200], e);
      end

      // R3: source enable subsets
      width_w = 3; height_l = 2; func = 8'hFE;
      base_a = 300; base_b = 400; base_c = 500; base_d = 600;
      stride_a = 1; stride_b = 2; stride_c = 0; stride_d = 4;
      for (int e = 0; e < 8; e++) begin
         src_en = 3'(e);
         run("R3", $countones(e) * 6);
      end

      // R4: geometry with strides
      src_en = 3'b011; func = 8'h3C; width_w = 5; height_l = 4;
      stride_a = 3; stride_b = 7; stride_d = 11;
      run("R4", 40);

      // R6: ascending shift sweep
      src_en = 3'b001; func = 8'hF0; width_w = 3; height_l = 3;
      base_a = 1000; base_d = 1100; stride_a = 2; stride_d = 5;
      for (int s = 0; s < 16; s++) begin shift = 4'(s); run("R6", 9); end

      // R7: descending shift sweep, bases name the last word
      descend = 1; base_a = 1300; base_d = 1400;
      for (int s = 0; s < 16; s++) begin shift = 4'(s); run("R7", 9); end
      shift = 0;

      // R5: overlapping descending move up by one word
      begin
         logic [15:0] snap [0:7];
         for (int i = 0; i < 8; i++) snap[i] = mem[1500 + i];
         width_w = 8; height_l = 1; stride_a = 0; stride_d = 0;
         base_a = 1507; base_d = 1508;
         run("R5", 8);
         for (int i = 0; i < 8; i++) check(mem[1501 + i] == snap[i], "R5", mem[1501 + i], snap[i]);
      end

      // R8: single-word span fill
      fill_en = 1; width_w = 1; base_a = 1700; base_d = 1701; mem[1700] = 16'h0810;
      run("R8", 1);
      check(mem[1701] == 16'h0FF0, "R8", mem[1701], 16'h0FF0);
      // R8: multi-word, multi-line fill in descending order
      width_w = 4; height_l = 3; base_a = 1811; base_d = 1911; stride_a = 0; stride_d = 2;
      for (int i = 1800; i < 1812; i++) mem[i] = (i % 3 == 0) ? 16'h0100 : 16'h0000;
      run("R8", 12);
      fill_en = 0; descend = 0;

      // R9: start while busy is ignored
      src_en = 3'b101; func = 8'h96; width_w = 4; height_l = 3;
      base_a = 2000; base_c = 2100; base_d = 2200; stride_a = 1; stride_c = 1; stride_d = 1;
      run("R9", 24, 1);

      // R10: full-size extents
      src_en = 0; func = 8'hFF; base_d = 2400; stride_d = 0;
      width_w = 64; height_l = 2;
      run("R10", 0);
      check(n_wr == 128, "R10", n_wr, 128);
      width_w = 1; height_l = 1024; base_d = 3000; func = 8'h00;
      run("R10", 0);
      check(n_wr == 1024, "R10", n_wr, 1024);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      wait (cyc >= 190000);
      timed_out = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule